// File: doc/BRIEF.md
# Two-Source Indexed Element Shuffle

This unit rearranges 128-bit vectors. Each element of the result is taken from a 2N-entry table made of two source operands. Operand k fills table entries 0 to N-1 and operand j fills entries N to 2N-1. The element count N is 128 divided by the element width. Element size is 8, 16, 32 or 64 bits.

The table index for result element i is read from element i of an index vector. Only the unsigned low byte of that index element is used, reduced modulo 2N. The index vector comes from one of two ports:

- a dedicated index port, used by the byte-size four-operand form;
- the old-destination port, used by the wider forms, whose result then replaces that destination.

Every result element is built from the values present in the accepted cycle. The same vector may therefore drive the index and a source at once without corrupting the result.

An operation is accepted when `in_valid` is high. The result is registered and appears one cycle later together with `out_valid`. The result register keeps its value while no operation is accepted.

Top module: `shuf_two_src`

## Requirements
- R1: The element width is 8, 16, 32 or 64 bits for `esize` = 0, 1, 2 or 3. There are N = 128/width elements, and element i occupies bits [i*width +: width] of every vector.
- R2: After reset `out_valid` is 0 and `result` is all zeros. `out_valid` equals the `in_valid` of the previous clock cycle.
- R3: In byte mode the index is reduced modulo 32. A reduced index r below 16 selects byte r of `src_k`; otherwise it selects byte r-16 of `src_j`.
- R4: In halfword mode the index is reduced modulo 16. Halfword r of `src_k` is selected for r < 8, else halfword r-8 of `src_j`.
- R5: In word mode the index is reduced modulo 8. Word r of `src_k` is selected for r < 4, else word r-4 of `src_j`.
- R6: In doubleword mode the index is reduced modulo 4. Doubleword r of `src_k` is selected for r < 2, else doubleword r-2 of `src_j`.
- R7: Bits of an index element above its low byte have no effect on the result. Bits of the low byte above the modulo range also have no effect.
- R8: `idx_sel` = 0 takes indices from `idx_vec`, and `idx_sel` = 1 takes them from `old_dst`. The unselected port has no effect.
- R9: While `in_valid` is low, `result` holds its last value whatever the data inputs do.
- R10: When the same vector drives `old_dst` and a source operand, the result is computed entirely from that cycle's input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept an operation this cycle |
| esize | input | 2 | Element size code (0 byte, 1 half, 2 word, 3 dword) |
| idx_sel | input | 1 | Index source: 0 index port, 1 old destination |
| src_j | input | 128 | Upper table half |
| src_k | input | 128 | Lower table half |
| idx_vec | input | 128 | Dedicated index vector |
| old_dst | input | 128 | Old destination value, usable as index vector |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Registered shuffle result |

## Verification
On every cycle the assertions check the one-cycle valid latency and that the result is held between operations. They also check, against a model written independently in the checker, byte element 0 in byte mode and doubleword element 0 in doubleword mode. The other element positions and the halfword and word sizes are covered only by the bench's scenarios. The same goes for the modulo wrap of large indices, the indifference to upper index bits and to the unselected index port, and the aliasing of index and source vectors.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    localparam int VEC_W   = 128;
    localparam int NUM_SZ  = 4;
    localparam int IDX_W   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } shuf_state_t;

endpackage

// File: rtl/shuf_idx_mux.sv
module shuf_idx_mux
    import shuf_pkg::*;
(
    input  logic             use_dst,
    input  logic [VEC_W-1:0] idx_port,
    input  logic [VEC_W-1:0] dst_port,
    output logic [VEC_W-1:0] idx_out
);

    always_comb begin
        idx_out = use_dst ? dst_port : idx_port;
    end

endmodule

// File: rtl/shuf_perm.sv
module shuf_perm
    import shuf_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [VEC_W-1:0] src_j,
    input  logic [VEC_W-1:0] src_k,
    input  logic [VEC_W-1:0] idx,
    output logic [VEC_W-1:0] perm_out
);

    localparam int N    = VEC_W / EW;
    localparam int TBL  = 2 * N;
    localparam int RW   = $clog2(TBL);

    logic [2*VEC_W-1:0] table_q;
    logic               unused_idx_hi;

    assign table_q       = {src_j, src_k};
    assign unused_idx_hi = ^idx;

    for (genvar g = 0; g < N; g++) begin : g_elem
        logic [RW-1:0] slot;
        // low byte reduced modulo 2N: power of two, so keep the low RW bits
        assign slot = idx[g*EW +: RW];
        assign perm_out[g*EW +: EW] = table_q[slot*EW +: EW];
    end

endmodule

// File: rtl/shuf_two_src.sv
module shuf_two_src
    import shuf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   esize,
    input  logic         idx_sel,
    input  logic [127:0] src_j,
    input  logic [127:0] src_k,
    input  logic [127:0] idx_vec,
    input  logic [127:0] old_dst,
    output logic         out_valid,
    output logic [127:0] result
);

    elem_size_e       size_e;
    logic [VEC_W-1:0] idx_eff;
    logic [VEC_W-1:0] perm_res [NUM_SZ];
    shuf_state_t      st_d, st_q;

    assign size_e = elem_size_e'(esize);

    shuf_idx_mux i_idx_mux (
        .use_dst  (idx_sel),
        .idx_port (idx_vec),
        .dst_port (old_dst),
        .idx_out  (idx_eff)
    );

    for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
        shuf_perm #(.EW(IDX_W << s)) i_perm (
            .src_j    (src_j),
            .src_k    (src_k),
            .idx      (idx_eff),
            .perm_out (perm_res[s])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (size_e)
                SZ_BYTE:  st_d.res = perm_res[0];
                SZ_HALF:  st_d.res = perm_res[1];
                SZ_WORD:  st_d.res = perm_res[2];
                SZ_DWORD: st_d.res = perm_res[3];
                default:  st_d.res = perm_res[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

endmodule

// File: rtl/shuf_two_src_chk.sv
module shuf_two_src_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   esize,
    input logic         idx_sel,
    input logic [127:0] src_j,
    input logic [127:0] src_k,
    input logic [127:0] idx_vec,
    input logic [127:0] old_dst,
    input logic         out_valid,
    input logic [127:0] result
);

    logic [127:0] ref_idx;
    logic [255:0] ref_tab;
    logic [4:0]   b0_slot;
    logic [1:0]   d0_slot;
    logic [7:0]   b0_exp;
    logic [63:0]  d0_exp;
    logic         unused_ref_idx;

    assign ref_idx        = idx_sel ? old_dst : idx_vec;
    assign ref_tab        = {src_j, src_k};
    assign b0_slot        = ref_idx[4:0];
    assign d0_slot        = ref_idx[1:0];
    assign b0_exp         = ref_tab[b0_slot*8 +: 8];
    assign d0_exp         = ref_tab[d0_slot*64 +: 64];
    assign unused_ref_idx = ^ref_idx;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(result));

    // R3
    byte_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(esize) == 2'd0)
            |-> result[7:0] == $past(b0_exp));

    // R6
    dword_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(esize) == 2'd3)
            |-> result[63:0] == $past(d0_exp));

endmodule

bind shuf_two_src shuf_two_src_chk i_shuf_two_src_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .esize     (esize),
    .idx_sel   (idx_sel),
    .src_j     (src_j),
    .src_k     (src_k),
    .idx_vec   (idx_vec),
    .old_dst   (old_dst),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_shuf_two_src.sv
module test_shuf_two_src;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   esize;
    logic         idx_sel;
    logic [127:0] src_j, src_k, idx_vec, old_dst;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    shuf_two_src i_shuf_two_src (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esize(esize),
        .idx_sel(idx_sel), .src_j(src_j), .src_k(src_k), .idx_vec(idx_vec),
        .old_dst(old_dst), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    task automatic rand_vec(output logic [127:0] v);
        for (int w = 0; w < 4; w++) begin
            seed = next_rand(seed);
            v[w*32 +: 32] = seed;
        end
    endtask

    // Model written from R1, R3-R7: low byte of each index element modulo 2N
    function automatic logic [127:0] model(input logic [1:0] es, input logic [127:0] j,
                                           input logic [127:0] k, input logic [127:0] ix);
        int ew = 8 << es;
        int n  = 128 / ew;
        logic [255:0] tab = {j, k};
        logic [127:0] o = '0;
        for (int i = 0; i < n; i++) begin
            int r = int'(ix[i*ew +: 8]) % (2 * n);
            for (int b = 0; b < ew; b++) o[i*ew + b] = tab[r*ew + b];
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one accepted operation; result sampled on the following falling edge
    task automatic fire(input logic [1:0] es, input logic sel, input logic [127:0] j,
                        input logic [127:0] k, input logic [127:0] ix, input logic [127:0] od);
        @(negedge clk);
        in_valid = 1'b1; esize = es; idx_sel = sel;
        src_j = j; src_k = k; idx_vec = ix; old_dst = od;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 reset valid", {127'd0, out_valid}, 128'd0);
        check("R2 reset result", result, 128'd0);
    endtask

    task automatic t_size(input logic [1:0] es, input string req);
        logic [127:0] j, k, ix, junk;
        for (int rep = 0; rep < 3; rep++) begin
            rand_vec(j); rand_vec(k); rand_vec(ix); rand_vec(junk);
            fire(es, 1'b0, j, k, ix, junk);
            check({req, " valid"}, {127'd0, out_valid}, 128'd1);
            check(req, result, model(es, j, k, ix));
        end
    endtask

    task automatic t_identity_bytes();
        logic [127:0] j, k, ix;
        rand_vec(j); rand_vec(k);
        for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'(i + 16);
        fire(2'd0, 1'b0, j, k, ix, '0);
        check("R3 upper half picks src_j", result, j);
        for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'(15 - i) | 8'hE0;
        fire(2'd0, 1'b0, j, k, ix, '0);
        for (int i = 0; i < 16; i++) check("R3 wrap reverse", {120'd0, result[i*8 +: 8]},
                                           {120'd0, k[(15-i)*8 +: 8]});
    endtask

    task automatic t_upper_bits();
        logic [127:0] j, k, ix, ix2;
        rand_vec(j); rand_vec(k); rand_vec(ix); rand_vec(ix2);
        for (int i = 0; i < 8; i++) ix2[i*16 +: 8] = ix[i*16 +: 8];
        fire(2'd1, 1'b0, j, k, ix, '0);
        check("R7 half ref", result, model(2'd1, j, k, ix));
        fire(2'd1, 1'b0, j, k, ix2, '0);
        check("R7 upper index bits ignored", result, model(2'd1, j, k, ix));
        for (int i = 0; i < 2; i++) ix2[i*64 +: 64] = {56'hFFFF_FFFF_FFFF_FF, 8'hFC | ix[i*64 +: 8]};
        fire(2'd3, 1'b0, j, k, ix2, '0);
        check("R7 dword modulo", result, model(2'd3, j, k, ix));
    endtask

    task automatic t_idx_sel();
        logic [127:0] j, k, a, b;
        rand_vec(j); rand_vec(k); rand_vec(a); rand_vec(b);
        fire(2'd0, 1'b0, j, k, a, b);
        check("R8 index port", result, model(2'd0, j, k, a));
        fire(2'd0, 1'b0, j, k, a, ~b);
        check("R8 old_dst ignored", result, model(2'd0, j, k, a));
        fire(2'd2, 1'b1, j, k, a, b);
        check("R8 old_dst port", result, model(2'd2, j, k, b));
        fire(2'd2, 1'b1, j, k, ~a, b);
        check("R8 idx_vec ignored", result, model(2'd2, j, k, b));
    endtask

    task automatic t_hold();
        logic [127:0] keep, x;
        keep = result;
        @(negedge clk);
        rand_vec(x); src_j = x; rand_vec(x); src_k = x; rand_vec(x); idx_vec = x;
        esize = 2'd3;
        @(negedge clk);
        @(negedge clk);
        check("R9 result held", result, keep);
        check("R2 valid low when idle", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic t_alias();
        logic [127:0] v, k;
        rand_vec(v); rand_vec(k);
        fire(2'd1, 1'b1, v, k, '0, v);
        check("R10 old_dst aliases src_j", result, model(2'd1, v, k, v));
        fire(2'd0, 1'b0, v, v, v, '0);
        check("R10 all operands aliased", result, model(2'd0, v, v, v));
    endtask

    initial begin
        fork
            begin
                rst_n = 1'b0; in_valid = 1'b0; esize = 2'd0; idx_sel = 1'b0;
                src_j = '0; src_k = '0; idx_vec = '0; old_dst = '0;
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_size(2'd0, "R3 byte");
                t_size(2'd1, "R4 half");
                t_size(2'd2, "R5 word");
                t_size(2'd3, "R6 dword");
                t_identity_bytes();
                t_upper_bits();
                t_idx_sel();
                t_hold();
                t_alias();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule